// File: doc/BRIEF.md
# Operand Hazard Interlock Unit

This block makes the stall and bypass decision for a short in-order pipeline with a fetch stage, an issue/address stage (II), an execute stage (EX) and a load-completion stage (EXD) that follows EX. Each cycle the instruction in II presents an optional address source, a set of data sources, a destination register and a producer kind. The block keeps its own record of the producers now in EX and EXD. It compares each live source against them and returns a single stall request plus one forwarding select per source.

Sources are split into two consumer classes. An address source feeds address generation, so its value must exist while the consumer is still in II. A data source is read only in EX: ALU, multiply and divide operands, store data and branch conditions. Producers are also split into two classes. An EX-ready producer (ALU, pair move, multiply, multiply-accumulate, divide micro-operation, base writeback) has its result at the end of EX. A load has its result only in EXD. The issue logic presents each micro-operation of a multi-word load or of a divide as its own II entry. For a multi-word load only the last micro-operation carries the load kind and the destination. When II is held, the block puts a bubble into its EX record. A flush empties both records.

Top module: `hz_interlock`

## Requirements
- R1: After synchronous reset both producer records are empty, so `stall` is 0 and every forwarding select reads 0 (register file) until new producers are issued.
- R2: A load (ii_kind = 2) followed directly by an instruction whose address source names its destination stalls that consumer for exactly two cycles. The consumer then issues with address select 0.
- R3: A load followed directly by an instruction whose data source names its destination stalls for exactly one cycle. That data select then reads 2 (from EXD).
- R4: An EX-ready producer (ii_kind = 1) followed directly by an address consumer of its destination stalls for one cycle. The address select then reads 2 (from EXD).
- R5: An EX-ready producer followed directly by a data consumer of its destination causes no stall, and that data select reads 1 (from EX).
- R6: When the matching producer sits in EXD with no match in EX, a data source selects 2 without a stall. An address source also selects 2 without a stall if the producer is EX-ready, and stalls if it is a load.
- R7: When both records match the same data source, the younger one in EX wins (select 1).
- R8: Register 0, and producers of kind 0 (no destination, which includes the unused code 3), never cause a stall or a non-zero select.
- R9: `flush` empties both producer records at the next edge, including the instruction in II during the flush cycle.
- R10: A source whose use bit is 0 never causes a stall or a non-zero select, whatever register it names.
- R11: `stall` is raised only while `ii_valid` is 1. While stalled or invalid, all selects read 0. An instruction that is stalled or invalid enters EX as a bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clears all tracked producers |
| ii_valid | input | 1 | An instruction occupies II |
| ii_kind | input | 2 | Producer kind: 0 none, 1 EX-ready, 2 load, 3 treated as none |
| ii_dst | input | 5 | Destination register of the II instruction |
| ii_addr_use | input | 1 | Address source is live |
| ii_addr_src | input | 5 | Address source register |
| ii_dat_use | input | 2 | Live bit per data source |
| ii_dat_src | input | 10 | Data source registers, source k in bits [5k+4:5k] |
| stall | output | 1 | Hold II and insert a bubble into EX |
| addr_fwd | output | 2 | Address select: 0 register file, 2 EXD |
| dat_fwd | output | 4 | Data select per source, source k in bits [2k+1:2k]: 0 file, 1 EX, 2 EXD |

## Verification
An address bypass from EXD and a data bypass from EX can both be needed in the same cycle. The bench provokes this by issuing two EX-ready producers back to back, followed by a consumer whose address source names the older producer and whose data source names the younger one. It expects no stall, an address select of 2 and a data select of 1. A second case puts a load-caused address stall in the same cycle as a data source that could otherwise have been bypassed from EXD. The stall must win, and every select must drop to 0.

// File: rtl/hz_pkg.sv
package hz_pkg;

    parameter int HZ_REG_W = 5;

    typedef enum logic [1:0] {
        PK_NONE = 2'd0,
        PK_EXR  = 2'd1,
        PK_LOAD = 2'd2
    } prod_kind_e;

    typedef enum logic [1:0] {
        FW_RF  = 2'd0,
        FW_EX  = 2'd1,
        FW_EXD = 2'd2
    } fwd_sel_e;

    typedef struct packed {
        logic                valid;
        prod_kind_e          kind;
        logic [HZ_REG_W-1:0] dst;
    } slot_t;

    // A slot can satisfy a source only if it really writes a non-zero register.
    function automatic logic slot_hits(slot_t s, logic [HZ_REG_W-1:0] r);
        return s.valid && (s.kind != PK_NONE) && (s.dst != '0) && (s.dst == r);
    endfunction

    function automatic prod_kind_e decode_kind(logic [1:0] code);
        case (code)
            2'd1:    return PK_EXR;
            2'd2:    return PK_LOAD;
            default: return PK_NONE;
        endcase
    endfunction

endpackage

// File: rtl/hz_slot_track.sv
module hz_slot_track
    import hz_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  logic  adv_valid,
    input  slot_t ii_slot,
    output slot_t ex_q,
    output slot_t exd_q
);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            ex_q  <= '0;
            exd_q <= '0;
        end else begin
            ex_q  <= adv_valid ? ii_slot : '0;
            exd_q <= ex_q;
        end
    end

    AST_BUBBLE_ON_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv_valid |=> !ex_q.valid); // R11

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!ex_q.valid && !exd_q.valid)); // R9

endmodule

// File: rtl/hz_src_cmp.sv
module hz_src_cmp
    import hz_pkg::*;
#(
    parameter bit IS_ADDR = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                use_i,
    input  logic [HZ_REG_W-1:0] src,
    input  slot_t               ex_s,
    input  slot_t               exd_s,
    output logic                hold,
    output fwd_sel_e            fwd
);

    logic hit_ex;
    logic hit_exd;

    assign hit_ex  = use_i && slot_hits(ex_s, src);
    assign hit_exd = use_i && slot_hits(exd_s, src);

    generate
        if (IS_ADDR) begin : g_addr
            // Address is consumed in II: anything still in EX is too late,
            // a load in EXD is still too late, an EX-ready result in EXD is usable.
            always_comb begin
                hold = hit_ex || (hit_exd && (exd_s.kind == PK_LOAD));
                fwd  = (!hold && hit_exd) ? FW_EXD : FW_RF;
            end
        end else begin : g_data
            // Data is consumed in EX: only a load still in EX is too late.
            always_comb begin
                hold = hit_ex && (ex_s.kind == PK_LOAD);
                if (hit_ex)
                    fwd = hold ? FW_RF : FW_EX;
                else if (hit_exd)
                    fwd = FW_EXD;
                else
                    fwd = FW_RF;
            end
        end
    endgenerate

    AST_ZERO_REG_SILENT: assert property (@(posedge clk) disable iff (rst)
        (src == '0) |-> (!hold && fwd == FW_RF)); // R8

    AST_UNUSED_SILENT: assert property (@(posedge clk) disable iff (rst)
        !use_i |-> (!hold && fwd == FW_RF)); // R10

endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
    import hz_pkg::*;
#(
    parameter int N_DAT = 2,
    localparam int REG_W = HZ_REG_W,
    localparam int SEL_W = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flush,
    input  logic                     ii_valid,
    input  logic [1:0]               ii_kind,
    input  logic [REG_W-1:0]         ii_dst,
    input  logic                     ii_addr_use,
    input  logic [REG_W-1:0]         ii_addr_src,
    input  logic [N_DAT-1:0]         ii_dat_use,
    input  logic [N_DAT*REG_W-1:0]   ii_dat_src,
    output logic                     stall,
    output logic [SEL_W-1:0]         addr_fwd,
    output logic [N_DAT*SEL_W-1:0]   dat_fwd
);

    slot_t    ii_slot;
    slot_t    ex_q;
    slot_t    exd_q;
    logic     addr_hold;
    fwd_sel_e addr_sel;
    logic     [N_DAT-1:0] dat_hold;
    fwd_sel_e dat_sel [N_DAT];
    logic     quiet;

    assign ii_slot.valid = ii_valid;
    assign ii_slot.kind  = decode_kind(ii_kind);
    assign ii_slot.dst   = ii_dst;

    hz_slot_track u_track (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .adv_valid (ii_valid && !stall),
        .ii_slot   (ii_slot),
        .ex_q      (ex_q),
        .exd_q     (exd_q)
    );

    hz_src_cmp #(.IS_ADDR(1'b1)) u_addr_cmp (
        .clk   (clk),
        .rst   (rst),
        .use_i (ii_addr_use),
        .src   (ii_addr_src),
        .ex_s  (ex_q),
        .exd_s (exd_q),
        .hold  (addr_hold),
        .fwd   (addr_sel)
    );

    generate
        for (genvar k = 0; k < N_DAT; k++) begin : g_dat
            hz_src_cmp #(.IS_ADDR(1'b0)) u_dat_cmp (
                .clk   (clk),
                .rst   (rst),
                .use_i (ii_dat_use[k]),
                .src   (ii_dat_src[k*REG_W +: REG_W]),
                .ex_s  (ex_q),
                .exd_s (exd_q),
                .hold  (dat_hold[k]),
                .fwd   (dat_sel[k])
            );
            assign dat_fwd[k*SEL_W +: SEL_W] = quiet ? SEL_W'(FW_RF) : dat_sel[k];
        end
    endgenerate

    assign stall    = ii_valid && (addr_hold || (|dat_hold));
    assign quiet    = stall || !ii_valid;
    assign addr_fwd = quiet ? SEL_W'(FW_RF) : addr_sel;

    AST_STALL_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        stall |-> ii_valid); // R11

    AST_FLUSH_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        flush |=> !stall); // R9

endmodule

// File: tb/hz_interlock_tb.sv
`timescale 1ns/1ps
module hz_interlock_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       flush = 1'b0;
    logic       ii_valid = 1'b0;
    logic [1:0] ii_kind = 2'd0;
    logic [4:0] ii_dst = 5'd0;
    logic       ii_addr_use = 1'b0;
    logic [4:0] ii_addr_src = 5'd0;
    logic [1:0] ii_dat_use = 2'd0;
    logic [9:0] ii_dat_src = 10'd0;
    logic       stall;
    logic [1:0] addr_fwd;
    logic [3:0] dat_fwd;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic       st;
        logic [1:0] af;
        logic [1:0] d0;
        logic [1:0] d1;
        string      tag;
    } exp_t;

    exp_t exq[$];

    always #2.5 clk = ~clk;

    hz_interlock u_dut (
        .clk         (clk),
        .rst         (rst),
        .flush       (flush),
        .ii_valid    (ii_valid),
        .ii_kind     (ii_kind),
        .ii_dst      (ii_dst),
        .ii_addr_use (ii_addr_use),
        .ii_addr_src (ii_addr_src),
        .ii_dat_use  (ii_dat_use),
        .ii_dat_src  (ii_dat_src),
        .stall       (stall),
        .addr_fwd    (addr_fwd),
        .dat_fwd     (dat_fwd)
    );

    localparam logic [1:0] K_NONE = 2'd0, K_EXR = 2'd1, K_LD = 2'd2;

    task automatic step(input logic v, input logic [1:0] k, input logic [4:0] dst,
                        input logic au, input logic [4:0] as_r,
                        input logic [1:0] du, input logic [4:0] s0, input logic [4:0] s1,
                        input logic fl,
                        input logic e_st, input logic [1:0] e_af,
                        input logic [1:0] e_d0, input logic [1:0] e_d1,
                        input string tag);
        exp_t e;
        @(negedge clk);
        ii_valid    = v;
        ii_kind     = k;
        ii_dst      = dst;
        ii_addr_use = au;
        ii_addr_src = as_r;
        ii_dat_use  = du;
        ii_dat_src  = {s1, s0};
        flush       = fl;
        e.st = e_st; e.af = e_af; e.d0 = e_d0; e.d1 = e_d1; e.tag = tag;
        exq.push_back(e);
    endtask

    // Monitor: samples 1 ns after the driver's negedge, well before the next posedge.
    always @(negedge clk) begin
        #1;
        if (exq.size() > 0) begin
            exp_t e;
            e = exq.pop_front();
            checks++;
            if (stall !== e.st || addr_fwd !== e.af ||
                dat_fwd[1:0] !== e.d0 || dat_fwd[3:2] !== e.d1) begin
                failures++;
                $display("FAIL %s: actual stall=%0d af=%0d d0=%0d d1=%0d expected stall=%0d af=%0d d0=%0d d1=%0d",
                         e.tag, stall, addr_fwd, dat_fwd[1:0], dat_fwd[3:2],
                         e.st, e.af, e.d0, e.d1);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: during reset, live sources and empty records
        step(1, K_NONE, 0, 1, 3, 2'b11, 3, 4, 0, 0, 0, 0, 0, "R1");
        @(negedge clk); rst = 1'b0;
        step(0, K_NONE, 0, 0, 0, 2'b00, 0, 0, 0, 0, 0, 0, 0, "R1");

        // R5: EX-ready producer r3 then data consumer of r3
        step(1, K_EXR, 3, 0, 0, 2'b00, 0, 0, 0, 0, 0, 0, 0, "R5");
        step(1, K_EXR, 4, 0, 0, 2'b01, 3, 0, 0, 0, 0, 1, 0, "R5");
        // R6: address from EXD (EX-ready r3) and data from EX (r4) in one cycle
        step(1, K_NONE, 0, 1, 3, 2'b10, 0, 4, 0, 0, 2, 0, 1, "R6");

        // R2: load r5 then address consumer: two stalls then issue
        step(1, K_LD, 5, 0, 0, 2'b00, 0, 0, 0, 0, 0, 0, 0, "R2");
        step(1, K_NONE, 0, 1, 5, 2'b00, 0, 0, 0, 1, 0, 0, 0, "R2");
        step(1, K_NONE, 0, 1, 5, 2'b00, 0, 0, 0, 1, 0, 0, 0, "R2");
        step(1, K_NONE, 0, 1, 5, 2'b00, 0, 0, 0, 0, 0, 0, 0, "R2");

        // R3: load r6 then data consumer: one stall then select EXD
        step(1, K_LD, 6, 0, 0, 2'b00, 0, 0, 0, 0, 0, 0, 0, "R3");
        step(1, K_NONE, 0, 0, 0, 2'b01, 6, 0, 0, 1, 0, 0, 0, "R3");
        step(1, K_NONE, 0, 0, 0, 2'b01, 6, 0, 0, 0, 0, 2, 0, "R3");

        // R4: EX-ready r7 then address consumer: one stall then select EXD
        step(1, K_EXR, 7, 0, 0, 2'b00, 0, 0, 0, 0, 0, 0, 0, "R4");
        step(1, K_NONE, 0, 1, 7, 2'b00, 0, 0, 0, 1, 0, 0, 0, "R4");
        step(1, K_NONE, 0, 1, 7, 2'b00, 0, 0, 0, 0, 2, 0, 0, "R4");

        // R7: r8 in both EX and EXD, both data sources pick EX
        step(1, K_EXR, 8, 0, 0, 2'b00, 0, 0, 0, 0, 0, 0, 0, "R7");
        step(1, K_EXR, 8, 0, 0, 2'b00, 0, 0, 0, 0, 0, 0, 0, "R7");
        step(1, K_NONE, 0, 0, 0, 2'b11, 8, 8, 0, 0, 0, 1, 1, "R7");

        // R8: destination r0, then a no-destination producer naming r9, then kind code 3
        step(1, K_EXR, 0, 0, 0, 2'b00, 0, 0, 0, 0, 0, 0, 0, "R8");
        step(1, K_NONE, 0, 1, 0, 2'b11, 0, 0, 0, 0, 0, 0, 0, "R8");
        step(1, K_NONE, 9, 0, 0, 2'b00, 0, 0, 0, 0, 0, 0, 0, "R8");
        step(1, K_NONE, 0, 1, 9, 2'b01, 9, 0, 0, 0, 0, 0, 0, "R8");
        step(1, 2'd3, 15, 0, 0, 2'b00, 0, 0, 0, 0, 0, 0, 0, "R8");
        step(1, K_NONE, 0, 1, 15, 2'b11, 15, 15, 0, 0, 0, 0, 0, "R8");

        // R10: load r10 then sources naming r10 with use bits clear
        step(1, K_LD, 10, 0, 0, 2'b00, 0, 0, 0, 0, 0, 0, 0, "R10");
        step(1, K_NONE, 0, 0, 10, 2'b00, 10, 10, 0, 0, 0, 0, 0, "R10");
        // R6: load r10 now in EXD, data source selects EXD without stall
        step(1, K_NONE, 0, 0, 0, 2'b10, 0, 10, 0, 0, 0, 0, 2, "R6");

        // R9: load r11 in EX is flushed; load r12 in II during flush never enters
        step(1, K_LD, 11, 0, 0, 2'b00, 0, 0, 0, 0, 0, 0, 0, "R9");
        step(1, K_LD, 12, 0, 0, 2'b00, 0, 0, 1, 0, 0, 0, 0, "R9");
        step(1, K_NONE, 0, 1, 11, 2'b01, 12, 0, 0, 0, 0, 0, 0, "R9");

        // R11: invalid instruction never stalls; stall zeroes selects; stalled producer is a bubble
        step(1, K_LD, 13, 0, 0, 2'b00, 0, 0, 0, 0, 0, 0, 0, "R11");
        step(0, K_NONE, 0, 1, 13, 2'b01, 13, 0, 0, 0, 0, 0, 0, "R11");
        step(1, K_EXR, 14, 1, 13, 2'b01, 13, 0, 0, 1, 0, 0, 0, "R11");
        step(1, K_NONE, 0, 1, 14, 2'b01, 14, 0, 0, 0, 0, 0, 0, "R11");

        step(0, K_NONE, 0, 0, 0, 2'b00, 0, 0, 0, 0, 0, 0, 0, "R1");
        @(negedge clk);
        #2;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule